// File: doc/BRIEF.md
# Accelerator Power-Domain Mode Controller

This block is a finite-state controller for the supply and clock of one accelerator power domain. It drives a voltage-level code, a frequency-select code, a clock-run enable and a power-switch enable. A frequency-scaling input chooses one of three active operating points. Pause requests carry a length class, and each class maps to a different low-power state:

- A short pause only stops the clock, and it wakes on the next cycle.
- A middle pause stops the clock and lowers the supply to its floor. Both entry and exit wait for the regulator to settle.
- A long pause first hands the domain to an external context-save engine. Once the save is done, the domain is powered off.

Waking from power-off raises the supply, waits for settling, and then asks a restore engine to reload the context before running again. An exit request powers the domain down from any state with no save. A settle-done input stands in for the regulator. A timeout aborts to power-off if settling never arrives. The current state is visible on a status output.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (off, no context), `vcode` is 0, `fsel` is 0, and `clk_en`, `pwr_en`, `save_req`, `restore_req` and `settle_err` are all low.
- R2: The `op_sel` values map to operating points as follows: 0 gives `vcode` 3 (1.2 V) with `fsel` 0, 1 gives `vcode` 2 (1.0 V) with `fsel` 1, and 2 or 3 give `vcode` 1 (0.9 V) with `fsel` 2. In state 1 (running), an `op_sel` that selects a different point moves the block to state 5 (settling) with the new codes and the clock stopped. The block returns to state 1 on the cycle after `settle_done`. An `op_sel` that selects the current point changes nothing.
- R3: A `pause_kind` of 0 (short) in state 1 moves the block to state 2 (clock stopped) on the next cycle, with `vcode` unchanged. A `resume_req` in state 2 returns the block to state 1 with the clock running on the next cycle.
- R4: A `pause_kind` of 1 (middle) in state 1 sets `vcode` to 1 and goes through state 5 to state 3 (low-voltage hold, clock stopped). A `resume_req` in state 3 restores the operating point's voltage through state 5. When the voltage is already 1, both moves skip state 5.
- R5: A `pause_kind` of 2 or 3 (long) in state 1 enters state 6 (saving). In that state `save_req` is high and power is held. On the cycle after `save_done`, the block is in state 4 (off, context saved) with `pwr_en` and `vcode` at 0.
- R6: A `resume_req` in state 4 powers on at the `op_sel` point and waits in state 5. `restore_req` rises only after `settle_done`, in state 7. The block reaches state 1 on the cycle after `restore_done`.
- R7: An `exit_req` in any state puts the block in state 0 with `pwr_en` low and `save_req` low on the next cycle.
- R8: Whenever `vcode` changes, `clk_en` is low in that cycle.
- R9: If `settle_done` is still absent on the SETTLE_TMO-th cycle in state 5, the block goes to state 0 and `settle_err` is high for one cycle. A `settle_done` on that same cycle completes normally instead.
- R10: While in states 5, 6 and 7, every request except `exit_req` is ignored.
- R11: In states 0 and 4, pause requests and `op_sel` changes are ignored. In state 2, `op_sel` changes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pause_req | input | 1 | Pause request, one cycle |
| pause_kind | input | 2 | Pause class: 0 short, 1 middle, 2/3 long |
| resume_req | input | 1 | Resume or power-up request |
| exit_req | input | 1 | Power-off request with no save |
| op_sel | input | 2 | Operating point selection |
| settle_done | input | 1 | Regulator has settled |
| save_done | input | 1 | Context save finished |
| restore_done | input | 1 | Context restore finished |
| vcode | output | 2 | Voltage code: 0 off, 1 0.9 V, 2 1.0 V, 3 1.2 V |
| fsel | output | 2 | Frequency select: 0 228 MHz, 1 152 MHz, 2 114 MHz |
| clk_en | output | 1 | Domain clock runs |
| pwr_en | output | 1 | Power switch closed |
| save_req | output | 1 | Request to the save engine |
| restore_req | output | 1 | Request to the restore engine |
| mode | output | 3 | Current state code |
| settle_err | output | 1 | Settling timeout pulse |

## Verification
Every state drives a distinct combination of `mode`, `vcode`, `clk_en`, `pwr_en` and the two engine requests. A wrong state or stored code therefore shows at the ports on the very cycle after the edge that caused it. A wrong remembered operating point stays hidden until a resume from the low-voltage hold. At that point it surfaces as a wrong `vcode`, or as a missing or extra pass through settling. A faulty timeout counter shows only as an early or late `settle_err`, exactly at the SETTLE_TMO boundary.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int SETTLE_TMO = 1024,
  localparam int CW = $clog2(SETTLE_TMO + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pause_req,
  input  logic [1:0] pause_kind,
  input  logic       resume_req,
  input  logic       exit_req,
  input  logic [1:0] op_sel,
  input  logic       settle_done,
  input  logic       save_done,
  input  logic       restore_done,
  output logic [1:0] vcode,
  output logic [1:0] fsel,
  output logic       clk_en,
  output logic       pwr_en,
  output logic       save_req,
  output logic       restore_req,
  output logic [2:0] mode,
  output logic       settle_err
);

  localparam logic [2:0] S_OFF  = 3'd0;
  localparam logic [2:0] S_RUN  = 3'd1;
  localparam logic [2:0] S_GATE = 3'd2;
  localparam logic [2:0] S_LOWV = 3'd3;
  localparam logic [2:0] S_SUSP = 3'd4;
  localparam logic [2:0] S_WAIT = 3'd5;
  localparam logic [2:0] S_SAVE = 3'd6;
  localparam logic [2:0] S_REST = 3'd7;
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_TMO - 1);

  logic [2:0]    st, tgt;
  logic [1:0]    v_q, f_q;
  logic [CW-1:0] cnt;
  logic          err_q;

  function automatic logic [1:0] volt_of(input logic [1:0] f);
    return (f == 2'd0) ? 2'd3 : (f == 2'd1) ? 2'd2 : 2'd1;
  endfunction

  wire [1:0] op_n = (op_sel == 2'd3) ? 2'd2 : op_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OFF;
      tgt   <= S_RUN;
      v_q   <= 2'd0;
      f_q   <= 2'd0;
      cnt   <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (exit_req) begin
        st  <= S_OFF;
        v_q <= 2'd0;
      end else begin
        case (st)
          S_OFF, S_SUSP:
            if (resume_req) begin
              f_q <= op_n;
              v_q <= volt_of(op_n);
              tgt <= (st == S_SUSP) ? S_REST : S_RUN;
              cnt <= '0;
              st  <= S_WAIT;
            end
          S_RUN:
            if (pause_req) begin
              if (pause_kind == 2'd0) st <= S_GATE;
              else if (pause_kind == 2'd1) begin
                if (v_q == 2'd1) st <= S_LOWV;
                else begin
                  v_q <= 2'd1;
                  tgt <= S_LOWV;
                  cnt <= '0;
                  st  <= S_WAIT;
                end
              end else st <= S_SAVE;
            end else if (op_n != f_q) begin
              f_q <= op_n;
              v_q <= volt_of(op_n);
              tgt <= S_RUN;
              cnt <= '0;
              st  <= S_WAIT;
            end
          S_GATE:
            if (resume_req) st <= S_RUN;
          S_LOWV:
            if (resume_req) begin
              if (volt_of(f_q) == v_q) st <= S_RUN;
              else begin
                v_q <= volt_of(f_q);
                tgt <= S_RUN;
                cnt <= '0;
                st  <= S_WAIT;
              end
            end
          S_WAIT:
            if (settle_done) st <= tgt;
            else if (cnt == CNT_LAST) begin
              err_q <= 1'b1;
              v_q   <= 2'd0;
              st    <= S_OFF;
            end else cnt <= cnt + 1'b1;
          S_SAVE:
            if (save_done) begin
              v_q <= 2'd0;
              st  <= S_SUSP;
            end
          S_REST:
            if (restore_done) st <= S_RUN;
          default: st <= S_OFF;
        endcase
      end
    end
  end

  assign vcode       = v_q;
  assign fsel        = f_q;
  assign pwr_en      = (v_q != 2'd0);
  assign clk_en      = (st == S_RUN) || (st == S_SAVE) || (st == S_REST);
  assign save_req    = (st == S_SAVE);
  assign restore_req = (st == S_REST);
  assign mode        = st;
  assign settle_err  = err_q;

  p_gate_on_vchange_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode != $past(vcode)) |-> !clk_en);

  p_exit_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> (mode == S_OFF && !pwr_en && !save_req));

  p_save_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !save_done && !exit_req) |=> (save_req && pwr_en));

  p_restore_after_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_req) |-> ($past(mode) == S_WAIT && $past(settle_done)));

  p_err_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    settle_err |-> (mode == S_OFF && !pwr_en));

  p_wait_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == S_WAIT && !settle_done && !exit_req && cnt != CNT_LAST) |=> (mode == S_WAIT && $stable(vcode)));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pause_req = 0, resume_req = 0, exit_req = 0;
  logic settle_done = 0, save_done = 0, restore_done = 0;
  logic [1:0] pause_kind = 0, op_sel = 0;
  logic [1:0] vcode, fsel;
  logic clk_en, pwr_en, save_req, restore_req, settle_err;
  logic [2:0] mode;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.SETTLE_TMO(TMO)) i_pwr_mode_ctrl (
    .clk, .rst_n, .pause_req, .pause_kind, .resume_req, .exit_req, .op_sel,
    .settle_done, .save_done, .restore_done, .vcode, .fsel, .clk_en, .pwr_en,
    .save_req, .restore_req, .mode, .settle_err);

  // stim {pause, kind[1:0], resume, exit, op[1:0], settle, save, restore}
  // exp  {mode[2:0], vcode[1:0], fsel[1:0], clk_en, pwr_en, save_req, restore_req}
  localparam logic [20:0] VEC [24] = '{
    21'b0_00_1_0_01_0_0_0_101_10_01_0_1_0_0,  // R2 power up to point 1
    21'b0_00_0_0_01_1_0_0_001_10_01_1_1_0_0,  // R2
    21'b1_00_0_0_01_0_0_0_010_10_01_0_1_0_0,  // R3 short pause
    21'b0_00_0_0_00_0_0_0_010_10_01_0_1_0_0,  // R11 op change ignored
    21'b0_00_1_0_01_0_0_0_001_10_01_1_1_0_0,  // R3 instant wake
    21'b0_00_0_0_00_0_0_0_101_11_00_0_1_0_0,  // R2 op change settles
    21'b1_00_0_0_00_0_0_0_101_11_00_0_1_0_0,  // R10 pause ignored
    21'b0_00_0_0_00_1_0_0_001_11_00_1_1_0_0,  // R2
    21'b1_01_0_0_00_0_0_0_101_01_00_0_1_0_0,  // R4 middle pause
    21'b0_00_0_0_00_1_0_0_011_01_00_0_1_0_0,  // R4
    21'b0_00_1_0_00_0_0_0_101_11_00_0_1_0_0,  // R4 resume raises voltage
    21'b0_00_0_0_00_1_0_0_001_11_00_1_1_0_0,  // R4
    21'b1_10_0_0_00_0_0_0_110_11_00_1_1_1_0,  // R5 long pause
    21'b0_00_1_0_00_0_0_0_110_11_00_1_1_1_0,  // R10 resume ignored in save
    21'b0_00_0_0_00_0_1_0_100_00_00_0_0_0_0,  // R5 off after save
    21'b1_00_0_0_00_0_0_0_100_00_00_0_0_0_0,  // R11 pause ignored off
    21'b0_00_1_0_10_0_0_0_101_01_10_0_1_0_0,  // R6 wake from suspend
    21'b0_00_0_0_10_1_0_0_111_01_10_1_1_0_1,  // R6 restore after settle
    21'b0_00_0_0_10_0_0_1_001_01_10_1_1_0_0,  // R6
    21'b1_01_0_0_10_0_0_0_011_01_10_0_1_0_0,  // R4 no settle at floor
    21'b0_00_1_0_10_0_0_0_001_01_10_1_1_0_0,  // R4
    21'b0_00_0_0_11_0_0_0_001_01_10_1_1_0_0,  // R2 code 3 equals 2
    21'b0_00_0_1_11_0_0_0_000_00_10_0_0_0_0,  // R7 exit
    21'b1_00_0_0_11_0_0_0_000_00_10_0_0_0_0   // R11 pause ignored off
  };
  string tags [24] = '{"R2","R2","R3","R11","R3","R2","R10","R2","R4","R4","R4","R4",
                       "R5","R10","R5","R11","R6","R6","R6","R4","R4","R2","R7","R11"};

  function automatic logic [10:0] outs();
    return {mode, vcode, fsel, clk_en, pwr_en, save_req, restore_req};
  endfunction

  task automatic chk(input string req, input logic [10:0] got, input logic [10:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic cyc(input logic [9:0] s);
    {pause_req, pause_kind, resume_req, exit_req, op_sel, settle_done, save_done, restore_done} = s;
    @(posedge clk);
    #2;
    {pause_req, resume_req, exit_req, settle_done, save_done, restore_done} = '0;
  endtask

  initial begin
    #3;
    chk("R1 reset", outs(), 11'b000_00_00_0_0_0_0);
    chk("R1 err", {10'd0, settle_err}, 11'd0);
    @(posedge clk); #2; rst_n = 1'b1;

    for (int i = 0; i < 24; i++) begin
      cyc(VEC[i][20:11]);
      chk(tags[i], outs(), VEC[i][10:0]);
    end

    // R9 timeout
    cyc(10'b0_00_1_0_00_0_0_0);
    for (int k = 0; k < TMO - 1; k++) cyc(10'b0_00_0_0_00_0_0_0);
    chk("R9 still settling", {mode, 7'd0, settle_err}, {3'd5, 8'd0});
    cyc(10'b0_00_0_0_00_0_0_0);
    chk("R9 timeout", {mode, vcode, 5'd0, settle_err}, {3'd0, 2'd0, 6'b000001});
    cyc(10'b0_00_0_0_00_0_0_0);
    chk("R9 pulse one cycle", {10'd0, settle_err}, 11'd0);

    // R9 settle on last cycle completes
    cyc(10'b0_00_1_0_00_0_0_0);
    for (int k = 0; k < TMO - 1; k++) cyc(10'b0_00_0_0_00_0_0_0);
    cyc(10'b0_00_0_0_00_1_0_0);
    chk("R9 boundary settle", {mode, vcode, 5'd0, settle_err}, {3'd1, 2'd3, 6'd0});

    // R7 exit during save
    cyc(10'b1_10_0_0_00_0_0_0);
    chk("R7 in save", outs(), 11'b110_11_00_1_1_1_0);
    cyc(10'b0_00_0_1_00_0_0_0);
    chk("R7 exit from save", outs(), 11'b000_00_00_0_0_0_0);

    // R7 exit during settle
    cyc(10'b0_00_1_0_01_0_0_0);
    cyc(10'b0_00_0_1_01_0_0_0);
    chk("R7 exit from settle", outs(), 11'b000_00_01_0_0_0_0);

    // R1 reset mid-run
    cyc(10'b0_00_1_0_00_0_0_0);
    cyc(10'b0_00_0_0_00_1_0_0);
    chk("R2 running again", outs(), 11'b001_11_00_1_1_0_0);
    rst_n = 1'b0; #1;
    chk("R1 async reset", outs(), 11'b000_00_00_0_0_0_0);
    @(posedge clk); #2; rst_n = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule